// File: doc/BRIEF.md
# Parallel EEPROM page write engine

This block is a clocked model of the write path of a byte-wide parallel EEPROM that sits behind a static-RAM style pin interface. Active-low chip enable, output enable and write enable pins are sampled on the system clock. Each write strobe deposits one byte into a page register that holds up to `PAGE_BYTES` bytes. The low address bits pick the byte slot and the upper address bits name the page. Bytes may arrive in any order, and a slot written twice keeps the later value.

A load window of `LOAD_WIN` clock cycles restarts with every accepted byte. When the window runs out, the engine enters a programming phase of `PROG_CYC` cycles (`PROG_CYC` must be at least `PAGE_BYTES`). In this phase it steps through the page slots and writes into the internal array only those slots that were loaded. The loaded-slot mask is then cleared and the engine goes idle. The array powers up erased, with every byte at `ERASED`.

From the first accepted byte until programming ends, the engine is busy, and a read returns status instead of array data. The top data bit is the inverse of the top bit of the last accepted byte. The next bit flips after each completed read. All lower bits read zero. The pins are plain level signals sampled every clock: there is no valid/ready handshake, so no back-pressure exists, and a host must pace its strobes itself.

Top module: `eep_page_writer`

## Requirements
- R1: After reset the engine is idle and every array byte reads `ERASED` (0xFF by default), so an immediate read returns true data.
- R2: A write strobe runs while `cs_n` and `wr_n` are both low and `rd_en_n` is high. The address is captured in the cycle the strobe begins (the later of the two falling edges). The data is captured in the cycle it ends (the first rising edge).
- R3: No byte is accepted while `rd_en_n` is held low, or while one of `cs_n` or `wr_n` stays high throughout. After such an attempt the engine stays idle and the array is unchanged.
- R4: The low 7 address bits select the slot within a page. Slots may be loaded in any order, and a slot rewritten during one load keeps the last value.
- R5: Every accepted byte restarts a `LOAD_WIN`-cycle window. When the window expires, programming starts, and strobes during programming are ignored.
- R6: During a page load, a strobe whose upper address bits differ from the page being loaded is discarded.
- R7: Only loaded slots are written to the array. Unloaded slots of the page keep their previous contents.
- R8: While busy, a read returns bit 7 equal to the inverse of bit 7 of the last accepted byte, with bits 5 to 0 at zero.
- R9: While busy, bit 6 inverts after each completed read. Once programming finishes it no longer toggles, and reads return array data.
- R10: `dout_en` is high exactly when `cs_n` and `rd_en_n` are both low. After programming ends, a read returns the programmed byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip enable, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; upper bits name the page, low PAGE_W bits the slot |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, or status while busy |
| dout_en | output | 1 | Output drive enable; low means the bus would float |

## Verification
If the loaded-slot mask or the page tag is wrong, the fault shows only after programming ends, at most `LOAD_WIN + PROG_CYC` cycles after the last byte. It appears as a wrong or missing byte in a page read-back, so every page is read back in full once the engine is idle. A wrong busy state or toggle register is visible at once: the very next read shows status where data was expected, or the reverse. A strobe capture fault likewise shows the wrong byte or the wrong slot on that page's read-back.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_t;
endpackage

// File: rtl/eep_strobe.sv
// Turns the sampled pin levels into a write-commit pulse and a read-end pulse.
module eep_strobe #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data,
  output logic              rd_end
);
  logic wr_act, wr_act_q, rd_act, rd_act_q;
  logic [ADDR_W-1:0] addr_lat;

  assign wr_act = ~cs_n & ~wr_n & rd_en_n;
  assign rd_act = ~cs_n & ~rd_en_n & wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      addr_lat <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act && !wr_act_q) addr_lat <= addr;
    end
  end

  assign commit   = wr_act_q & ~wr_act;
  assign cmt_addr = addr_lat;
  assign cmt_data = din;
  assign rd_end   = rd_act_q & ~rd_act;
endmodule

// File: rtl/eep_page_buf.sv
// Page register with a per-slot loaded mask.
module eep_page_buf #(
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PAGE_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      clr,
  input  logic [PAGE_W-1:0]         rd_idx,
  output logic [DATA_W-1:0]         rd_data,
  output logic [(1<<PAGE_W)-1:0]    valid_mask
);
  localparam int SLOTS = 1 << PAGE_W;
  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g]     <= '0;
        valid_mask[g] <= 1'b0;
      end else if (wr_en && wr_idx == PAGE_W'(g)) begin
        slot_q[g]     <= wr_data;
        valid_mask[g] <= 1'b1;
      end else if (clr) begin
        valid_mask[g] <= 1'b0;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/eep_seq.sv
// Load window, programming sequencer, polling and toggle status.
module eep_seq
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 7,
  parameter int DATA_W   = 8,
  parameter int LOAD_WIN = 40,
  parameter int PROG_CYC = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] cmt_addr,
  input  logic [DATA_W-1:0] cmt_data,
  input  logic              rd_end,
  input  logic              slot_loaded,
  output logic              buf_wr,
  output logic              buf_clr,
  output logic [PAGE_W-1:0] prog_idx,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output eep_state_t        state,
  output logic              last_msb,
  output logic              tog
);
  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam int WCW   = (LOAD_WIN > 1) ? $clog2(LOAD_WIN) : 1;
  localparam int PCW   = $clog2(PROG_CYC);
  localparam logic [WCW-1:0] WIN_LAST  = WCW'(LOAD_WIN - 1);
  localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYC - 1);
  localparam logic [PCW-1:0] SLOT_LIM  = PCW'(1 << PAGE_W);

  logic [TAG_W-1:0] tag_q;
  logic [WCW-1:0]   win_cnt;
  logic [PCW-1:0]   prog_cnt;
  logic             accept;
  logic [TAG_W-1:0] cmt_tag;

  assign cmt_tag = cmt_addr[ADDR_W-1:PAGE_W];
  assign accept  = commit && ((state == ST_IDLE) ||
                              (state == ST_LOAD && cmt_tag == tag_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tag_q    <= '0;
      win_cnt  <= '0;
      prog_cnt <= '0;
      last_msb <= 1'b0;
      tog      <= 1'b0;
    end else begin
      if (accept) last_msb <= cmt_data[DATA_W-1];
      if (state != ST_IDLE && rd_end) tog <= ~tog;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            tag_q   <= cmt_tag;
            win_cnt <= '0;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            win_cnt <= '0;
          end else if (win_cnt == WIN_LAST) begin
            prog_cnt <= '0;
            state    <= ST_PROG;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (prog_cnt == PROG_LAST) state <= ST_IDLE;
          else prog_cnt <= prog_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign buf_wr   = accept;
  assign buf_clr  = (state == ST_PROG) && (prog_cnt == PROG_LAST);
  assign prog_idx = prog_cnt[PAGE_W-1:0];
  assign mem_we   = (state == ST_PROG) && (prog_cnt < SLOT_LIM) && slot_loaded;
  assign mem_addr = {tag_q, prog_idx};
endmodule

// File: rtl/eep_array.sv
// Nonvolatile byte array model: one write port, asynchronous read.
module eep_array #(
  parameter int          ADDR_W = 11,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  ERASED = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(ERASED);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter int         PAGE_W   = 7,
  parameter int         DATA_W   = 8,
  parameter int         LOAD_WIN = 40,
  parameter int         PROG_CYC = 160,
  parameter logic [7:0] ERASED   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int SLOTS = 1 << PAGE_W;

  logic              commit, rd_end, buf_wr, buf_clr, mem_we, last_msb, tog, busy;
  logic [ADDR_W-1:0] cmt_addr, mem_addr;
  logic [DATA_W-1:0] cmt_data, buf_rd, arr_rd;
  logic [PAGE_W-1:0] prog_idx;
  logic [SLOTS-1:0]  valid_mask;
  eep_state_t        state;

  eep_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en_n(rd_en_n), .wr_n(wr_n),
    .addr(addr), .din(din), .commit(commit), .cmt_addr(cmt_addr),
    .cmt_data(cmt_data), .rd_end(rd_end)
  );

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_idx(cmt_addr[PAGE_W-1:0]),
    .wr_data(cmt_data), .clr(buf_clr), .rd_idx(prog_idx), .rd_data(buf_rd),
    .valid_mask(valid_mask)
  );

  eep_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cmt_addr(cmt_addr),
    .cmt_data(cmt_data), .rd_end(rd_end), .slot_loaded(valid_mask[prog_idx]),
    .buf_wr(buf_wr), .buf_clr(buf_clr), .prog_idx(prog_idx), .mem_we(mem_we),
    .mem_addr(mem_addr), .state(state), .last_msb(last_msb), .tog(tog)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASED(ERASED)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(buf_rd),
    .raddr(addr), .rdata(arr_rd)
  );

  assign busy    = (state != ST_IDLE);
  assign dout    = busy ? {~last_msb, tog, {(DATA_W-2){1'b0}}} : arr_rd;
  assign dout_en = ~cs_n & ~rd_en_n;
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
  import eep_pkg::*;
#(
  parameter int SLOTS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en_n,
  input logic             commit,
  input logic             busy,
  input logic             mem_we,
  input eep_state_t       state,
  input logic             tog,
  input logic [SLOTS-1:0] valid_mask
);
  AST_ARRAY_WR_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> state == ST_PROG); // R7
  AST_COMMIT_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(rd_en_n)); // R3
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid_mask == '0); // R7
  AST_TOG_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(tog)); // R9
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit)); // R5
endmodule

bind eep_page_writer eep_page_writer_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .commit(commit), .busy(busy),
  .mem_we(mem_we), .state(state), .tog(tog), .valid_mask(valid_mask)
);

// File: tb/tb_eep_page_writer.sv
`timescale 1ns/1ps
module tb_eep_page_writer;
  localparam int ADDR_W = 11, PAGE_W = 7, DATA_W = 8;
  localparam int LOAD_WIN = 40, PROG_CYC = 160;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_en_n = 1, wr_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_en;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_mem [DEPTH];

  always #2 clk = ~clk;

  eep_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en_n(rd_en_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int off);
    return ADDR_W'((tag << PAGE_W) | (off & (SLOTS - 1)));
  endfunction

  function automatic logic [7:0] status_of(input logic [7:0] last, input logic t);
    return {~last[7], t, 6'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; rd_en_n = 1; cs_n = 0; wr_n = 0;
    @(negedge clk);
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic en);
    @(negedge clk); addr = a; wr_n = 1; cs_n = 0; rd_en_n = 0;
    @(negedge clk); v = dout; en = dout_en; cs_n = 1; rd_en_n = 1;
  endtask

  task automatic wait_idle();
    repeat (LOAD_WIN + PROG_CYC + 20) @(negedge clk);
  endtask

  task automatic check_page(input string req, input int tag);
    logic [7:0] v; logic en;
    for (int o = 0; o < SLOTS; o++) begin
      rd(mk(tag, o), v, en);
      chk(req, v, exp_mem[mk(tag, o)]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v1, v2, v3;
    logic en;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R10: reset state and drive enable
    chk("R10 dout_en idle", {7'b0, dout_en}, 8'h00);
    rd(mk(0, 0), v, en);
    chk("R1 erased", v, 8'hFF);
    chk("R10 dout_en on read", {7'b0, en}, 8'h01);
    rd(mk(15, 127), v, en);
    chk("R1 erased top", v, 8'hFF);

    // R4 / R7: any order, rewrite, unloaded slots untouched
    wr(mk(3, 5), 8'h11); exp_mem[mk(3, 5)] = 8'h11;
    wr(mk(3, 2), 8'h22); exp_mem[mk(3, 2)] = 8'h22;
    wr(mk(3, 5), 8'h33); exp_mem[mk(3, 5)] = 8'h33;
    wr(mk(3, 127), 8'h44); exp_mem[mk(3, 127)] = 8'h44;
    wait_idle();
    rd(mk(3, 5), v, en); chk("R4 last value wins", v, 8'h33);
    rd(mk(3, 6), v, en); chk("R7 unloaded slot", v, 8'hFF);
    check_page("R7 page readback", 3);

    // R8 / R9: polling and toggle status
    wr(mk(1, 9), 8'h3C); exp_mem[mk(1, 9)] = 8'h3C;
    rd(mk(1, 9), v1, en);
    rd(mk(1, 9), v2, en);
    rd(mk(1, 9), v3, en);
    chk("R8 polling bit busy", v1 & 8'hBF, status_of(8'h3C, 1'b0) & 8'hBF);
    chk("R8 polling second read", v2 & 8'hBF, 8'h80);
    chk("R9 toggle flips", {7'b0, v2[6]}, {7'b0, ~v1[6]});
    chk("R9 toggle flips again", {7'b0, v3[6]}, {7'b0, ~v2[6]});
    wait_idle();
    rd(mk(1, 9), v1, en);
    rd(mk(1, 9), v2, en);
    chk("R10 true data after done", v1, 8'h3C);
    chk("R9 no toggle after done", v2, 8'h3C);

    // R3: inhibit with output enable low
    @(negedge clk); addr = mk(2, 40); din = 8'h00; cs_n = 0; wr_n = 0; rd_en_n = 0;
    repeat (2) @(negedge clk); wr_n = 1; cs_n = 1; rd_en_n = 1;
    rd(mk(2, 40), v, en); chk("R3 oe low inhibits", v, 8'hFF);
    // R3: chip enable held high during a write-enable pulse
    @(negedge clk); addr = mk(2, 41); din = 8'h00; cs_n = 1; wr_n = 0;
    repeat (2) @(negedge clk); wr_n = 1;
    rd(mk(2, 41), v, en); chk("R3 cs high inhibits", v, 8'hFF);

    // R2: chip-enable-controlled write, address and data capture points
    @(negedge clk); wr_n = 0; cs_n = 1; rd_en_n = 1;
    @(negedge clk); addr = mk(2, 10); din = 8'h11; cs_n = 0;
    @(negedge clk); addr = mk(2, 11); din = 8'h5A;
    @(negedge clk); din = 8'h77;
    @(negedge clk); cs_n = 1;
    @(negedge clk); wr_n = 1;
    exp_mem[mk(2, 10)] = 8'h77;
    wait_idle();
    rd(mk(2, 10), v, en); chk("R2 addr at start data at end", v, 8'h77);
    rd(mk(2, 11), v, en); chk("R2 later address unused", v, 8'hFF);

    // R6: page change during load is discarded
    wr(mk(4, 0), 8'hAA); exp_mem[mk(4, 0)] = 8'hAA;
    wr(mk(5, 0), 8'hBB);
    wait_idle();
    rd(mk(4, 0), v, en); chk("R6 own page written", v, 8'hAA);
    rd(mk(5, 0), v, en); chk("R6 other page discarded", v, 8'hFF);

    // R5: window expiry starts programming; writes then ignored
    wr(mk(6, 1), 8'h12); exp_mem[mk(6, 1)] = 8'h12;
    repeat (LOAD_WIN + 10) @(negedge clk);
    wr(mk(6, 2), 8'h34);
    wait_idle();
    rd(mk(6, 1), v, en); chk("R5 first byte programmed", v, 8'h12);
    rd(mk(6, 2), v, en); chk("R5 write during programming ignored", v, 8'hFF);

    // R4 / R7: full page
    for (int o = 0; o < SLOTS; o++) begin
      wr(mk(7, SLOTS - 1 - o), 8'(o) ^ 8'h5A);
      exp_mem[mk(7, SLOTS - 1 - o)] = 8'(o) ^ 8'h5A;
    end
    wait_idle();
    check_page("R4 full page", 7);

    // R4 / R5 / R7: random pages with gaps inside the window
    for (int p = 0; p < 10; p++) begin
      int tag, n;
      tag = 8 + int'($urandom % 8);
      n = 1 + int'($urandom % 24);
      for (int k = 0; k < n; k++) begin
        int off;
        logic [7:0] d;
        off = int'($urandom % SLOTS);
        d = 8'($urandom);
        wr(mk(tag, off), d);
        exp_mem[mk(tag, off)] = d;
        repeat (int'($urandom % 9)) @(negedge clk);
      end
      wait_idle();
      check_page("R5 random page", tag);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule